// File: doc/BRIEF.md
# Four-Channel Overtemperature Comparator with Release Hysteresis

This block watches the results of a temperature converter for four monitored channels. Each time a conversion finishes, the converter presents a strobe, the channel index and a signed temperature in whole degrees. The block compares that temperature with the channel's programmable trip threshold and keeps one sticky trip state per channel. A channel trips when its temperature rises strictly above its threshold. It releases only after the temperature falls more than a fixed 4 degrees below that threshold. A temperature inside the 4-degree band leaves the state as it was.

The four trip states are reported as status bits. They are also combined into a single active-low overtemperature pin, which can drive a fan, a throttling request or a shutdown. Each channel can be kept off the pin by a bit in a configuration byte, and those mask bits sit at fixed, non-adjacent positions. Thresholds are written through a simple write port. Bus decoding and the analog measurement sit outside this block.

Top module: `ot_monitor`

## Requirements
- R1: While `rst` is high at a rising edge, every trip state clears, so `ot_status` reads 0 and `ot_n` reads 1 after that edge. Every threshold returns to the parameter `DEF_THR`, which defaults to +110.
- R2: A conversion with a temperature strictly greater than the selected channel's threshold sets that channel's trip state. A temperature equal to the threshold leaves a clear state clear. The new state is visible on `ot_status` after the clock edge that samples `conv_done`.
- R3: A tripped channel clears only when a conversion reports a temperature strictly below its threshold minus 4. A temperature from threshold minus 4 up to the threshold keeps it tripped.
- R4: A channel's state changes only at an edge where `conv_done` is 1 and `conv_chan` selects that channel. All other channels hold their states.
- R5: The release level is formed at 9 bits, so it cannot wrap. With a threshold of -128, a tripped channel never releases, even at a reading of -128.
- R6: Thresholds and temperatures are 8-bit two's complement. When `thr_we` is 1 at an edge, the threshold of channel `thr_sel` takes `thr_wdata`. A conversion sampled at the same edge compares against the threshold value held before that write.
- R7: Bits 0, 3, 4 and 5 of `cfg_ovt` mask channels 0, 1, 2 and 3 from `ot_n`. Bits 7, 6, 2 and 1 have no effect on `ot_n` or on `ot_status`.
- R8: `ot_n` is 0 exactly when at least one unmasked channel is tripped. The mask takes effect in the same cycle, with no register in the path. Masking never changes `ot_status`.
- R9: Bit i of `ot_status` is the trip state of channel i, where channel i is addressed by the value i on `conv_chan` and `thr_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_done | input | 1 | Strobe: one conversion result is present |
| conv_chan | input | 2 | Channel index of the conversion |
| conv_temp | input | 8 | Converted temperature, signed, whole degrees |
| thr_we | input | 1 | Threshold write enable |
| thr_sel | input | 2 | Channel whose threshold is written |
| thr_wdata | input | 8 | New threshold, signed, whole degrees |
| cfg_ovt | input | 8 | Configuration byte holding the pin mask bits |
| ot_status | output | 4 | Per-channel trip state |
| ot_n | output | 1 | Combined overtemperature pin, active low |

## Verification
A wrong trip state shows up on `ot_status` at the first edge after the conversion that caused it. It also shows on `ot_n` in that same cycle, unless the channel is masked. A release level that is off by one degree, or that wraps, is exposed by readings placed exactly at threshold minus 4 and minus 5, and by a threshold of -128. A stale or misrouted threshold does not appear until the next conversion on that channel lands near the boundary, so the random stimulus keeps its readings within a few degrees of the stored thresholds.

// File: rtl/ot_pkg.sv
package ot_pkg;

    localparam int OT_NCH  = 4;
    localparam int OT_TW   = 8;
    localparam int OT_HYST = 4;
    localparam int OT_CFGW = 8;

    typedef enum logic {
        OT_CLEAR   = 1'b0,
        OT_TRIPPED = 1'b1
    } ot_state_e;

    // Position of a channel's mask bit inside the configuration byte.
    function automatic int unsigned mask_pos(input int unsigned ch);
        case (ch)
            0:       return 0;
            1:       return 3;
            2:       return 4;
            3:       return 5;
            default: return 0;
        endcase
    endfunction

    // Builds a per-channel enable vector from the configuration byte.
    function automatic logic [OT_NCH-1:0] unmasked(input logic [OT_CFGW-1:0] cfg);
        logic [OT_NCH-1:0] en;
        for (int i = 0; i < OT_NCH; i++) begin
            en[i] = ~cfg[mask_pos(i)];
        end
        return en;
    endfunction

endpackage

// File: rtl/ot_thr_bank.sv
module ot_thr_bank #(
    parameter int N_CH    = ot_pkg::OT_NCH,
    parameter int TW      = ot_pkg::OT_TW,
    parameter int DEF_THR = 110,
    localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CH_W-1:0]   sel,
    input  logic [TW-1:0]     wdata,
    output logic [N_CH*TW-1:0] thr_flat
);

    localparam logic [TW-1:0] RST_VAL = TW'(DEF_THR);

    for (genvar i = 0; i < N_CH; i++) begin : g_thr
        logic [TW-1:0] thr_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                thr_q <= RST_VAL;
            end else if (we && (sel == CH_W'(i))) begin
                thr_q <= wdata;
            end
        end

        assign thr_flat[i*TW +: TW] = thr_q;
    end

endmodule

// File: rtl/ot_chan_cmp.sv
module ot_chan_cmp #(
    parameter int TW   = ot_pkg::OT_TW,
    parameter int HYST = ot_pkg::OT_HYST
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] thr,
    output logic          tripped
);

    import ot_pkg::*;

    localparam int WW = TW + 1;

    ot_state_e         state_q, state_d;
    logic signed [WW-1:0] temp_w, thr_w, rel_w;

    // Widen by one bit so threshold minus hysteresis cannot wrap.
    always_comb begin
        temp_w = $signed({temp[TW-1], temp});
        thr_w  = $signed({thr[TW-1], thr});
        rel_w  = thr_w - $signed(WW'(HYST));
    end

    always_comb begin
        state_d = state_q;
        if (upd) begin
            unique case (state_q)
                OT_CLEAR:   if (temp_w > thr_w) state_d = OT_TRIPPED;
                OT_TRIPPED: if (temp_w < rel_w) state_d = OT_CLEAR;
                default:    state_d = OT_CLEAR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OT_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    assign tripped = (state_q == OT_TRIPPED);

endmodule

// File: rtl/ot_out_merge.sv
module ot_out_merge #(
    parameter int N_CH  = ot_pkg::OT_NCH,
    parameter int CFG_W = ot_pkg::OT_CFGW
) (
    input  logic [N_CH-1:0]  state,
    input  logic [CFG_W-1:0] cfg,
    output logic             ot_n
);

    logic [N_CH-1:0] active;

    for (genvar i = 0; i < N_CH; i++) begin : g_en
        localparam int unsigned POS = ot_pkg::mask_pos(i);
        if (POS < CFG_W) begin : g_ok
            assign active[i] = state[i] & ~cfg[POS];
        end else begin : g_nomask
            assign active[i] = state[i];
        end
    end

    assign ot_n = ~(|active);

endmodule

// File: rtl/ot_monitor.sv
module ot_monitor #(
    parameter int N_CH    = ot_pkg::OT_NCH,
    parameter int TW      = ot_pkg::OT_TW,
    parameter int HYST    = ot_pkg::OT_HYST,
    parameter int CFG_W   = ot_pkg::OT_CFGW,
    parameter int DEF_THR = 110,
    localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_done,
    input  logic [CH_W-1:0]  conv_chan,
    input  logic [TW-1:0]    conv_temp,
    input  logic             thr_we,
    input  logic [CH_W-1:0]  thr_sel,
    input  logic [TW-1:0]    thr_wdata,
    input  logic [CFG_W-1:0] cfg_ovt,
    output logic [N_CH-1:0]  ot_status,
    output logic             ot_n
);

    logic [N_CH*TW-1:0] thr_flat;

    ot_thr_bank #(
        .N_CH    (N_CH),
        .TW      (TW),
        .DEF_THR (DEF_THR)
    ) thr_i (
        .clk      (clk),
        .rst      (rst),
        .we       (thr_we),
        .sel      (thr_sel),
        .wdata    (thr_wdata),
        .thr_flat (thr_flat)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic hit;
        assign hit = conv_done && (conv_chan == CH_W'(i));

        ot_chan_cmp #(
            .TW   (TW),
            .HYST (HYST)
        ) cmp_i (
            .clk     (clk),
            .rst     (rst),
            .upd     (hit),
            .temp    (conv_temp),
            .thr     (thr_flat[i*TW +: TW]),
            .tripped (ot_status[i])
        );
    end

    ot_out_merge #(
        .N_CH  (N_CH),
        .CFG_W (CFG_W)
    ) merge_i (
        .state (ot_status),
        .cfg   (cfg_ovt),
        .ot_n  (ot_n)
    );

endmodule

// File: rtl/ot_monitor_chk.sv
module ot_monitor_chk #(
    parameter int N_CH  = 4,
    parameter int TW    = 8,
    parameter int HYST  = 4,
    parameter int CFG_W = 8,
    parameter int CH_W  = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             conv_done,
    input logic [CH_W-1:0]  conv_chan,
    input logic [TW-1:0]    conv_temp,
    input logic [N_CH*TW-1:0] thr_flat,
    input logic [CFG_W-1:0] cfg_ovt,
    input logic [N_CH-1:0]  ot_status,
    input logic             ot_n
);

    logic signed [TW:0] t_w, thr_w;
    logic [N_CH-1:0]    sel_oh;
    logic [N_CH-1:0]    en;

    always_comb begin
        t_w    = $signed({conv_temp[TW-1], conv_temp});
        thr_w  = $signed({thr_flat[conv_chan*TW + TW-1], thr_flat[conv_chan*TW +: TW]});
        sel_oh = '0;
        sel_oh[conv_chan] = 1'b1;
        for (int i = 0; i < N_CH; i++) begin
            en[i] = ~cfg_ovt[ot_pkg::mask_pos(i)];
        end
    end

    // R1: reset leaves all states clear and the pin released
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (ot_status == '0) && ot_n);

    // R2: reading above threshold trips the addressed channel
    p_trip_above_r2: assert property (@(posedge clk) disable iff (rst)
        (conv_done && (t_w > thr_w)) |=> (ot_status & $past(sel_oh)) != '0);

    // R3: reading below release level clears the addressed channel
    p_release_below_r3: assert property (@(posedge clk) disable iff (rst)
        (conv_done && (t_w < thr_w - $signed((TW+1)'(HYST)))) |=> (ot_status & $past(sel_oh)) == '0);

    // R4: channels not addressed hold their state
    p_others_hold_r4: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> ((ot_status ^ $past(ot_status)) & ~$past(sel_oh)) == '0);

    // R4: no strobe, no change
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !conv_done |=> $stable(ot_status));

    // R8: pin reflects unmasked trip states
    p_pin_merge_r8: assert property (@(posedge clk) disable iff (rst)
        ot_n == ((ot_status & en) == '0));

endmodule

bind ot_monitor ot_monitor_chk #(
    .N_CH  (N_CH),
    .TW    (TW),
    .HYST  (HYST),
    .CFG_W (CFG_W),
    .CH_W  (CH_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .conv_done (conv_done),
    .conv_chan (conv_chan),
    .conv_temp (conv_temp),
    .thr_flat  (thr_flat),
    .cfg_ovt   (cfg_ovt),
    .ot_status (ot_status),
    .ot_n      (ot_n)
);

// File: tb/ot_monitor_tb.sv
module ot_monitor_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       conv_done;
    logic [1:0] conv_chan;
    logic [7:0] conv_temp;
    logic       thr_we;
    logic [1:0] thr_sel;
    logic [7:0] thr_wdata;
    logic [7:0] cfg_ovt;
    logic [3:0] ot_status;
    logic       ot_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int thr_m [4];
    bit st_m  [4];

    always #2 clk = ~clk;

    ot_monitor dut_i (
        .clk       (clk),
        .rst       (rst),
        .conv_done (conv_done),
        .conv_chan (conv_chan),
        .conv_temp (conv_temp),
        .thr_we    (thr_we),
        .thr_sel   (thr_sel),
        .thr_wdata (thr_wdata),
        .cfg_ovt   (cfg_ovt),
        .ot_status (ot_status),
        .ot_n      (ot_n)
    );

    function automatic bit next_state(bit st, int temp, int thr);
        if (st) return (temp < thr - 4) ? 1'b0 : 1'b1;
        return (temp > thr) ? 1'b1 : 1'b0;
    endfunction

    function automatic logic [3:0] exp_status();
        logic [3:0] s;
        for (int i = 0; i < 4; i++) s[i] = st_m[i];
        return s;
    endfunction

    function automatic logic exp_pin(logic [7:0] cfg);
        logic [3:0] s = exp_status();
        logic [3:0] en = {~cfg[5], ~cfg[4], ~cfg[3], ~cfg[0]};
        return ((s & en) == 4'b0);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check({req, " status"}, {4'b0, ot_status}, {4'b0, exp_status()});
        check({req, " pin"}, {7'b0, ot_n}, {7'b0, exp_pin(cfg_ovt)});
    endtask

    // Drive one cycle with optional conversion and optional threshold write.
    task automatic cycle(bit cv, int ch, int temp, bit wr, int wsel, int wval);
        @(negedge clk);
        conv_done = cv;
        conv_chan = 2'(ch);
        conv_temp = 8'(temp);
        thr_we    = wr;
        thr_sel   = 2'(wsel);
        thr_wdata = 8'(wval);
        @(negedge clk);
        conv_done = 1'b0;
        thr_we    = 1'b0;
        if (cv) st_m[ch] = next_state(st_m[ch], temp, thr_m[ch]);
        if (wr) thr_m[wsel] = wval;
    endtask

    task automatic conv(int ch, int temp);
        cycle(1, ch, temp, 0, 0, 0);
    endtask

    task automatic wthr(int ch, int val);
        cycle(0, 0, 0, 1, ch, val);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            st_m[i]  = 0;
            thr_m[i] = 110;
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; conv_done = 0; conv_chan = 0; conv_temp = 0;
        thr_we = 0; thr_sel = 0; thr_wdata = 0; cfg_ovt = 8'h00;
        repeat (3) @(negedge clk);
        do_reset();
        check_all("R1 reset");

        // R1: default threshold 110 — 110 holds clear, 111 trips
        conv(0, 110);
        check_all("R2 equal-threshold no trip");
        conv(0, 111);
        check_all("R1 default threshold trips");

        // R3: band edges at threshold-4 and threshold-5
        conv(0, 106);
        check_all("R3 hold at thr-4");
        conv(0, 108);
        check_all("R3 hold in band");
        conv(0, 105);
        check_all("R3 release below thr-4");

        // R9 / R4: each channel addressed individually
        for (int c = 0; c < 4; c++) begin
            wthr(c, 20 + c);
        end
        conv(2, 30);
        check_all("R9 channel 2 bit");
        check({"R4 others hold"}, {4'b0, ot_status & 4'b1011}, 8'h00);
        @(negedge clk);
        @(negedge clk);
        check_all("R4 no strobe holds");

        // R6: negative threshold, signed compare
        wthr(1, -10);
        conv(1, -9);
        check_all("R6 signed trip");
        conv(1, -14);
        check_all("R6 signed hold at thr-4");
        conv(1, -15);
        check_all("R6 signed release");

        // R6: same-edge write and conversion uses old threshold (21 on ch1 ... now -10)
        cycle(1, 1, 0, 1, 1, 50);
        check_all("R6 old threshold at write edge");
        conv(1, 0);
        check_all("R6 new threshold after write");

        // R5: threshold -128 never releases
        wthr(3, -128);
        conv(3, -127);
        check_all("R5 trip near floor");
        conv(3, -128);
        check_all("R5 no release at floor");

        // R7 / R8: mask positions and reserved bits
        wthr(0, 0); wthr(1, 0); wthr(2, 0);
        conv(0, 5); conv(1, 5); conv(2, 5);
        cfg_ovt = 8'b1100_0110;
        #1 check_all("R7 reserved bits ignored");
        cfg_ovt = 8'b0011_1001;
        #1 check_all("R7 all masked");
        check("R8 mask leaves status", {4'b0, ot_status}, 8'h0F);
        for (int b = 0; b < 8; b++) begin
            cfg_ovt = 8'b0011_1001 & ~(8'h01 << b);
            #1 check_all("R7 single unmask");
        end
        cfg_ovt = 8'h00;

        // Random stimulus near thresholds
        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < 3000; n++) begin
            int op = $urandom_range(0, 99);
            int ch = $urandom_range(0, 3);
            if (op < 65) begin
                int t = thr_m[ch] + $urandom_range(0, 14) - 7;
                if (t > 127) t = 127;
                if (t < -128) t = -128;
                conv(ch, t);
                check_all("R2 R3 random conversion");
            end else if (op < 80) begin
                wthr(ch, $urandom_range(0, 255) - 128);
                check_all("R6 random write");
            end else if (op < 95) begin
                cfg_ovt = 8'($urandom_range(0, 255));
                #1 check_all("R8 random mask");
            end else begin
                do_reset();
                check_all("R1 random reset");
            end
        end

        done = 1;
        finish_run();
    end

endmodule